// File: doc/BRIEF.md
# Monochrome Scanline Pixel Serializer

This block turns a one-bit-per-pixel frame buffer into a serial video level during the visible part of each scanline. A line strobe opens a line. After a fixed lead-in that covers the sync pulse and the back porch, the block streams a fixed number of pixels. It fetches 16-bit words from a synchronous read port with one cycle of latency and shifts each word out from its most significant bit down. Each pixel holds its level for two or three clocks, chosen by a select input that is latched when the line opens.

Word addresses run on without a break from line to line. A line always uses a whole number of eight-word groups, and a frame-start pulse sends the read address back to zero. The next word is fetched well before the current one runs out, so pixels follow each other with no gaps. Outside the visible window the output stays low, which is black.

Top module: `mono_pix_serializer`

## Requirements
- R1: While reset is held and right after it is released, pix_out is 0, fb_rd_en is 0 and fb_rd_addr is 0.
- R2: With pix_period_sel = 0 every pixel lasts 2 clocks, and with pix_period_sel = 1 it lasts 3 clocks. The select is latched at the accepted line strobe, and a change later in the line has no effect on that line.
- R3: Pixel x of a line comes from bit (15 − x mod 16) of the line's word x/16, so each word goes out most significant bit first. A bit of 1 drives pix_out high and a bit of 0 drives it low.
- R4: Each line reads exactly LINE_GROUPS × 8 words (16 by default) through fb_rd_en/fb_rd_addr, at consecutive addresses. The data are sampled one cycle after the read, and the address carries on from where the previous line stopped.
- R5: Pixel 0 is on pix_out after the LEAD_CLKS-th rising edge following the edge that sampled line_start (180 by default). Each later pixel follows the one before it directly, with no idle clock between words.
- R6: pix_out is 0 from the line strobe until pixel 0 appears. It is 0 again from the edge that ends the last pixel until the next line's pixel 0.
- R7: A frame_start pulse makes the next read use address 0.
- R8: A line_start pulse that arrives while a line is in its lead-in or visible phase is ignored, and the line in progress is output unchanged.
- R9: A frame buffer holding only zero words produces only black pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that rewinds the read address to 0 |
| line_start | input | 1 | One-cycle pulse that opens a scanline |
| pix_period_sel | input | 1 | Pixel length: 0 = 2 clocks, 1 = 3 clocks |
| fb_rd_data | input | WORD_W | Frame-buffer word, valid the cycle after a read |
| fb_rd_en | output | 1 | Frame-buffer read enable |
| fb_rd_addr | output | ADDR_W | Frame-buffer word address |
| pix_out | output | 1 | Serial video level (1 = white, 0 = black) |

## Verification
The bench compares every clock of each line against a bit model of the frame buffer. Because of this, a design that starts one clock early or late, picks bits in reverse order, or leaves a gap while it reloads a word fails the pixel check for that line. The select is flipped in the middle of a line, and a second line strobe arrives while pixels are streaming; a design that re-samples the select or restarts the line would bend the pixel pattern from that point on. Read counts and the last address of each line catch a fetch that runs one word too far or too short, and a frame start that fails to rewind. An all-zero buffer confirms that nothing but black leaks out, even at word edges.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_ACTIVE = 2'd2
    } line_state_e;

    typedef enum logic {
        PER_TWO   = 1'b0,
        PER_THREE = 1'b1
    } pix_period_e;

    // Per-edge control handed from the sequencer to the shifter
    typedef struct packed {
        logic show;   // present a new pixel on the next edge
        logic load;   // the new pixel starts a fresh word
        logic blank;  // force black on the next edge
    } shift_ctl_t;

    // Last phase value of a pixel for the chosen period
    function automatic logic [1:0] period_last(pix_period_e p);
        return (p == PER_THREE) ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/sps_sequencer.sv
module sps_sequencer
    import sps_pkg::*;
#(
    parameter int HRES      = 256,
    parameter int WORD_W    = 16,
    parameter int LEAD_CLKS = 180
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        line_start,
    input  pix_period_e period_sel,
    output shift_ctl_t  ctl,
    output logic        fetch_req,
    output line_state_e state_o
);
    localparam int PIX_W      = $clog2(HRES);
    localparam int BIT_W      = $clog2(WORD_W);
    localparam int LEAD_W     = $clog2(LEAD_CLKS);
    localparam int WPL        = HRES / WORD_W;
    localparam int WORD_IDX_W = PIX_W - BIT_W;

    line_state_e        st_q;
    logic [LEAD_W-1:0]  lead_q;
    logic [1:0]         ph_q;
    logic [PIX_W-1:0]   pidx_q;
    pix_period_e        per_q;

    logic               accept;
    logic               lead_done;
    logic               tick;
    logic               last_pix;
    logic [PIX_W-1:0]   next_pix;
    logic [WORD_IDX_W-1:0] next_word;

    always_comb begin
        accept    = line_start && (st_q == ST_IDLE);
        lead_done = (st_q == ST_LEAD) && (lead_q == LEAD_W'(LEAD_CLKS - 1));
        tick      = (st_q == ST_ACTIVE) && (ph_q == period_last(per_q));
        last_pix  = (pidx_q == PIX_W'(HRES - 1));
        next_pix  = lead_done ? '0 : pidx_q + 1'b1;
        next_word = next_pix[PIX_W-1:BIT_W];

        ctl.show  = lead_done || (tick && !last_pix);
        ctl.load  = ctl.show && (next_pix[BIT_W-1:0] == '0);
        ctl.blank = tick && last_pix;

        fetch_req = accept || (ctl.load && (next_word != WORD_IDX_W'(WPL - 1)));
        state_o   = st_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            lead_q <= '0;
            ph_q   <= '0;
            pidx_q <= '0;
            per_q  <= PER_TWO;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        st_q   <= ST_LEAD;
                        lead_q <= '0;
                        per_q  <= period_sel;
                    end
                end
                ST_LEAD: begin
                    if (lead_done) begin
                        st_q   <= ST_ACTIVE;
                        ph_q   <= '0;
                        pidx_q <= '0;
                    end else begin
                        lead_q <= lead_q + 1'b1;
                    end
                end
                ST_ACTIVE: begin
                    if (tick) begin
                        ph_q   <= '0;
                        pidx_q <= next_pix;
                        if (last_pix) st_q <= ST_IDLE;
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R2: the latched period never moves while a line is open
    p_period_lock_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE) |=> $stable(per_q));

endmodule

// File: rtl/sps_fetch.sv
module sps_fetch #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              req,
    input  logic              load,
    input  logic [WORD_W-1:0] rd_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] word_out
);
    logic              pend_q;
    logic              buf_valid_q;
    logic [WORD_W-1:0] buf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_en       <= 1'b0;
            rd_addr     <= '0;
            pend_q      <= 1'b0;
            buf_valid_q <= 1'b0;
            buf_q       <= '0;
        end else begin
            rd_en  <= req;
            pend_q <= rd_en;
            if (frame_start)
                rd_addr <= '0;
            else if (rd_en)
                rd_addr <= rd_addr + 1'b1;
            if (pend_q) begin
                buf_q       <= rd_data;
                buf_valid_q <= 1'b1;
            end else if (load) begin
                buf_valid_q <= 1'b0;
            end
        end
    end

    assign word_out = buf_q;

    // R4: a word is always waiting when the shifter takes one
    p_load_has_word_r4: assert property (@(posedge clk) disable iff (rst)
        load |-> buf_valid_q);

    // R4: returning data never lands on an unused word
    p_no_overrun_r4: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> !buf_valid_q);

endmodule

// File: rtl/sps_shifter.sv
module sps_shifter
    import sps_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  shift_ctl_t        ctl,
    input  logic [WORD_W-1:0] word_in,
    output logic              pix_out
);
    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            pix_out <= 1'b0;
        end else if (ctl.blank) begin
            pix_out <= 1'b0;
        end else if (ctl.show && ctl.load) begin
            pix_out <= word_in[WORD_W-1];
            sh_q    <= {word_in[WORD_W-2:0], 1'b0};
        end else if (ctl.show) begin
            pix_out <= sh_q[WORD_W-1];
            sh_q    <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/mono_pix_serializer.sv
module mono_pix_serializer
    import sps_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int BURST_WORDS = 8,
    parameter int LINE_GROUPS = 2,
    parameter int LEAD_CLKS   = 180,
    parameter int ADDR_W      = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              pix_period_sel,
    input  logic [WORD_W-1:0] fb_rd_data,
    output logic              fb_rd_en,
    output logic [ADDR_W-1:0] fb_rd_addr,
    output logic              pix_out
);
    localparam int WORDS_PER_LINE  = LINE_GROUPS * BURST_WORDS;
    localparam int PIXELS_PER_LINE = WORDS_PER_LINE * WORD_W;

    shift_ctl_t        ctl;
    logic              fetch_req;
    line_state_e       seq_state;
    logic [WORD_W-1:0] word;

    sps_sequencer #(
        .HRES      (PIXELS_PER_LINE),
        .WORD_W    (WORD_W),
        .LEAD_CLKS (LEAD_CLKS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .period_sel (pix_period_e'(pix_period_sel)),
        .ctl        (ctl),
        .fetch_req  (fetch_req),
        .state_o    (seq_state)
    );

    sps_fetch #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .req         (fetch_req),
        .load        (ctl.load),
        .rd_data     (fb_rd_data),
        .rd_en       (fb_rd_en),
        .rd_addr     (fb_rd_addr),
        .word_out    (word)
    );

    sps_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .word_in (word),
        .pix_out (pix_out)
    );

    // R6: black whenever no visible pixel is being streamed
    p_black_outside_r6: assert property (@(posedge clk) disable iff (rst)
        (seq_state != ST_ACTIVE) |-> !pix_out);

    // R4: reads happen only while a line is open
    p_fetch_in_line_r4: assert property (@(posedge clk) disable iff (rst)
        fb_rd_en |-> (seq_state != ST_IDLE));

endmodule

// File: tb/mono_pix_serializer_test.sv
module mono_pix_serializer_test;

    localparam int CLK_PERIOD = 10;
    localparam int LEAD       = 180;
    localparam int WPL        = 16;
    localparam int HRES       = WPL * 16;
    localparam int MEMW       = 64;

    // {frame_start, period_sel, mid-line select flip, mid-line strobe}
    localparam logic [3:0] LINE_VEC [0:5] = '{
        4'b1000, 4'b0100, 4'b0011, 4'b0110, 4'b1101, 4'b0000
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic        pix_period_sel = 1'b0;
    logic [15:0] fb_rd_data = '0;
    logic        fb_rd_en;
    logic [11:0] fb_rd_addr;
    logic        pix_out;

    logic [15:0] mem [0:MEMW-1];
    int          rd_total = 0;
    logic [11:0] rd_last = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_base = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mono_pix_serializer uut (
        .clk            (clk),
        .rst            (rst),
        .frame_start    (frame_start),
        .line_start     (line_start),
        .pix_period_sel (pix_period_sel),
        .fb_rd_data     (fb_rd_data),
        .fb_rd_en       (fb_rd_en),
        .fb_rd_addr     (fb_rd_addr),
        .pix_out        (pix_out)
    );

    // Frame-buffer model: synchronous read, one cycle latency
    always @(posedge clk) begin
        if (fb_rd_en) begin
            fb_rd_data <= mem[fb_rd_addr[5:0]];
            rd_total   <= rd_total + 1;
            rd_last    <= fb_rd_addr;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_line(input bit fs, input bit mode, input bit tog, input bit str,
                            input string tag);
        int pix_err   = 0;
        int blank_err = 0;
        int bad_act   = 0;
        int bad_exp   = 0;
        int reads0;
        int per       = mode ? 3 : 2;
        int vis_end   = LEAD + HRES * per;
        if (fs) begin
            @(negedge clk) frame_start = 1'b1;
            @(negedge clk) frame_start = 1'b0;
            exp_base = 0;
        end
        pix_period_sel = mode;
        reads0 = rd_total;
        @(negedge clk) line_start = 1'b1;
        @(negedge clk) line_start = 1'b0;
        for (int c = 1; c <= vis_end + 5; c++) begin
            logic        e;
            logic [15:0] w;
            int          k;
            @(negedge clk);
            line_start = str && (c == LEAD + 50);
            if (tog && c == LEAD + 10) pix_period_sel = !mode;
            e = 1'b0;
            if (c >= LEAD && c < vis_end) begin
                k = (c - LEAD) / per;
                w = mem[(exp_base + k / 16) % MEMW];
                e = w[15 - (k % 16)];
                if (pix_out !== e) begin
                    if (pix_err == 0) begin bad_act = int'(pix_out); bad_exp = int'(e); end
                    pix_err++;
                end
            end else if (pix_out !== 1'b0) begin
                blank_err++;
            end
        end
        line_start     = 1'b0;
        pix_period_sel = mode;
        check(pix_err == 0, {tag, " pixel stream (first mismatch value)"}, bad_act, bad_exp);
        check(blank_err == 0, "R6 black outside window (bad cycles)", blank_err, 0);
        check(rd_total - reads0 == WPL, "R4 words read per line", rd_total - reads0, WPL);
        check(int'(rd_last) == exp_base + WPL - 1,
              fs ? "R7 last address after frame start" : "R4 last address continues",
              int'(rd_last), exp_base + WPL - 1);
        if (str) check(pix_err == 0 && blank_err == 0, "R8 strobe during line ignored",
                       pix_err + blank_err, 0);
        if (tog) check(pix_err == 0, "R2 mid-line select change ignored", pix_err, 0);
        exp_base += WPL;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEMW; i++)
            mem[i] = 16'(i * 16'h3B1D) ^ 16'hC35A;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(pix_out == 1'b0, "R1 pix_out in reset", int'(pix_out), 0);
        check(fb_rd_en == 1'b0, "R1 fb_rd_en in reset", int'(fb_rd_en), 0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check(fb_rd_addr == '0, "R1 address after reset", int'(fb_rd_addr), 0);
        check(pix_out == 1'b0, "R1 pix_out after reset", int'(pix_out), 0);

        // Table-driven lines: period, bit order, timing, fetch, rewind
        for (int v = 0; v < 6; v++)
            run_line(LINE_VEC[v][3], LINE_VEC[v][2], LINE_VEC[v][1], LINE_VEC[v][0],
                     LINE_VEC[v][2] ? "R2 R3 R5 three-clock" : "R2 R3 R5 two-clock");

        // R9: an all-zero buffer yields black only
        for (int i = 0; i < MEMW; i++) mem[i] = '0;
        run_line(1'b1, 1'b1, 1'b0, 1'b0, "R9 zero buffer");

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule